// File: doc/BRIEF.md
# Bank-Selecting I2C EEPROM Slave

This block is the serial protocol engine for the one port of a three-bank serial EEPROM that can both write and read. It samples the SCL and SDA bus lines with the system clock. Each line goes through a two-stage synchronizer and a three-sample majority vote. The engine then recognises START and STOP conditions and the rising and falling clock edges. It answers a slave address made of a fixed device-type nibble, a zero bit, two bank-select bits and a direction bit. Bank-select code 00 selects nothing and is refused.

Writes are passed to an external write sequencer. Each received data byte is handed over as a push that carries the bank, the byte address and the data. A STOP then raises a commit pulse, or an abort pulse when the enable pin has dropped. If the transfer is broken off by a repeated START, an abort pulse is raised instead. The sequencer owns the write cycle: it reports busy and stores the bytes through a program port into the banked register array. Reads are served straight from that array. Each bank keeps its own 8-bit address counter, which supports random, current and sequential reads. SDA is driven only as an open-drain pull-down enable.

Top module: `eeprom_bank_i2c_slave`

## Requirements
- R1: The address byte must be 1010 in bits 7..4 and 0 in bit 3. Any other address byte gets no acknowledge, and the slave leaves SDA released until the next START.
- R2: Bits 2..1 of the address byte select the bank: 01, 10 and 11 select banks 1, 2 and 3 (program index 0, 1, 2). Code 00 gets no acknowledge.
- R3: While `wr_en_i` is low, no address is acknowledged. If `wr_en_i` is low when the STOP arrives, staged write bytes are dropped through an abort pulse and the memory is unchanged.
- R4: While `seq_busy_i` is high, every address byte gets no acknowledge.
- R5: A write acknowledges each byte and pushes each data byte with its bank and address. Only address bits 2..0 advance, so an 8-byte page wraps on itself and the bytes outside the page are untouched. A STOP with `wr_en_i` high raises one commit pulse, never in the same cycle as a push.
- R6: A START that arrives after staged data bytes, with no STOP first, raises an abort pulse. Those bytes are never stored.
- R7: A random read returns the addressed byte, MSB first. The slave changes SDA only after a falling SCL edge, START or STOP. It keeps SDA released during the master's acknowledge slot.
- R8: When the master acknowledges a read byte, the slave sends the byte at the next address, and the address wraps from FFh to 00h within the same bank. After a not-acknowledge, SDA stays released.
- R9: A current read returns the byte at the last read address plus one if the last access was a read. It returns the byte at the last written address if the last access was a write.
- R10: After reset, every stored byte is FFh, every bank counter is 00h and SDA is released.
- R11: Each bank's address counter changes only when that bank is accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull SDA low when high |
| wr_en_i | input | 1 | Port enable; high allows access |
| seq_busy_i | input | 1 | Write sequencer is in its write cycle |
| pg_push_o | output | 1 | One data byte staged for writing |
| pg_commit_o | output | 1 | Start the write cycle for the staged bytes |
| pg_abort_o | output | 1 | Drop the staged bytes |
| pg_bank_o | output | 2 | Bank index of the pushed byte |
| pg_addr_o | output | 8 | Address of the pushed byte |
| pg_data_o | output | 8 | Pushed data byte |
| prog_we_i | input | 1 | Sequencer write strobe into the array |
| prog_bank_i | input | 2 | Bank index for the array write |
| prog_addr_i | input | 8 | Address for the array write |
| prog_data_i | input | 8 | Data for the array write |

## Verification
Two functions can fall in the same cycle. One is the address acknowledge decision. The other is a change of sequencer busy or of the enable pin, because both inputs are sampled on the same falling edge that ends the address byte. The bench provokes this by sending an address right after a committed write, while the sequencer model is still holding busy. It also drops the enable pin between the last data byte and the STOP. Each case is judged at the bus: the acknowledge bit must read high, and a later read-back must return the old memory contents.

// File: rtl/i2c_bank_pkg.sv
package i2c_bank_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ACK,
        S_WADDR,
        S_WDATA,
        S_RDATA,
        S_RACK,
        S_RLOAD,
        S_WAIT
    } slv_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    function automatic logic maj3(input logic [2:0] v);
        return (v[0] & v[1]) | (v[1] & v[2]) | (v[0] & v[2]);
    endfunction

    function automatic logic [7:0] page_next(input logic [7:0] a, input int pbits);
        logic [7:0] m;
        m = 8'((1 << pbits) - 1);
        return (a & ~m) | ((a + 8'd1) & m);
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int NLINES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] raw_i,
    output logic [NLINES-1:0] filt_o
);
    import i2c_bank_pkg::*;

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic s1, s2;
        logic [2:0] hist;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1        <= 1'b1;
                s2        <= 1'b1;
                hist      <= 3'b111;
                filt_o[g] <= 1'b1;
            end else begin
                s1        <= raw_i[g];
                s2        <= s1;
                hist      <= {hist[1:0], s2};
                filt_o[g] <= maj3(hist);
            end
        end
    end

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_f,
    input  logic                   sda_f,
    output i2c_bank_pkg::bus_evt_t evt_o
);
    logic prev_scl, prev_sda;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_scl <= 1'b1;
            prev_sda <= 1'b1;
        end else begin
            prev_scl <= scl_f;
            prev_sda <= sda_f;
        end
    end

    always_comb begin
        evt_o.start = prev_scl & scl_f & prev_sda & ~sda_f;
        evt_o.stop  = prev_scl & scl_f & ~prev_sda & sda_f;
        evt_o.rise  = ~prev_scl & scl_f;
        evt_o.fall  = prev_scl & ~scl_f;
        evt_o.sda   = sda_f;
    end

    // R1: a START is only reported while the clock line was high on the previous sample
    assert_start_scl_high_R1: assert property (@(posedge clk) disable iff (rst)
        evt_o.start |-> $past(scl_f));

endmodule

// File: rtl/bank_store.sv
module bank_store #(
    parameter int NBANK  = 3,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int BANK_W = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [BANK_W-1:0] wbank_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [BANK_W-1:0] rbank_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [NBANK][DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NBANK; b++)
                for (int a = 0; a < DEPTH; a++)
                    mem[b][a] <= '1;
        end else if (we_i && (int'(wbank_i) < NBANK)) begin
            mem[wbank_i][waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = (int'(rbank_i) < NBANK) ? mem[rbank_i][raddr_i] : '1;

    // R5: a program strobe leaves the addressed cell holding the written byte
    assert_prog_write_R5: assert property (@(posedge clk) disable iff (rst)
        (we_i && int'(wbank_i) < NBANK && !rst) |=> (mem[$past(wbank_i)][$past(waddr_i)] == $past(wdata_i)));

endmodule

// File: rtl/eeprom_bank_i2c_slave.sv
module eeprom_bank_i2c_slave #(
    parameter int NBANK     = 3,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 3,
    parameter int BANK_W    = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              wr_en_i,
    input  logic              seq_busy_i,
    output logic              pg_push_o,
    output logic              pg_commit_o,
    output logic              pg_abort_o,
    output logic [BANK_W-1:0] pg_bank_o,
    output logic [ADDR_W-1:0] pg_addr_o,
    output logic [DATA_W-1:0] pg_data_o,
    input  logic              prog_we_i,
    input  logic [BANK_W-1:0] prog_bank_i,
    input  logic [ADDR_W-1:0] prog_addr_i,
    input  logic [DATA_W-1:0] prog_data_i
);
    import i2c_bank_pkg::*;

    localparam int CNT_W = $clog2(DATA_W) + 1;

    logic [1:0]        filt;
    bus_evt_t          evt;
    slv_state_e        state, after_ack;
    logic [CNT_W-1:0]  bitcnt;
    logic [DATA_W-1:0] rxsh, txsh, rd_byte;
    logic              sda_drv, is_read, staged;
    logic [BANK_W-1:0] cur_bank;
    logic [ADDR_W-1:0] wptr;
    logic [ADDR_W-1:0] ctr [NBANK];
    logic              addr_ok;
    logic [BANK_W-1:0] sel_bank;

    i2c_line_filter #(.NLINES(2)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .raw_i  ({scl_i, sda_i}),
        .filt_o (filt)
    );

    i2c_cond_detect u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_f (filt[1]),
        .sda_f (filt[0]),
        .evt_o (evt)
    );

    bank_store #(.NBANK(NBANK), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we_i    (prog_we_i),
        .wbank_i (prog_bank_i),
        .waddr_i (prog_addr_i),
        .wdata_i (prog_data_i),
        .rbank_i (cur_bank),
        .raddr_i (ctr[cur_bank]),
        .rdata_o (rd_byte)
    );

    always_comb begin
        sel_bank = BANK_W'(rxsh[2:1] - 2'd1);
        addr_ok  = (rxsh[7:4] == DEV_TYPE) && !rxsh[3] && (rxsh[2:1] != 2'b00)
                   && (int'(sel_bank) < NBANK) && wr_en_i && !seq_busy_i;
    end

    assign sda_oe_o = sda_drv;

    always_ff @(posedge clk) begin
        pg_push_o   <= 1'b0;
        pg_commit_o <= 1'b0;
        pg_abort_o  <= 1'b0;
        if (rst) begin
            state     <= S_IDLE;
            after_ack <= S_IDLE;
            bitcnt    <= '0;
            rxsh      <= '0;
            txsh      <= '0;
            sda_drv   <= 1'b0;
            is_read   <= 1'b0;
            staged    <= 1'b0;
            cur_bank  <= '0;
            wptr      <= '0;
            pg_bank_o <= '0;
            pg_addr_o <= '0;
            pg_data_o <= '0;
            for (int b = 0; b < NBANK; b++) ctr[b] <= '0;
        end else if (evt.start) begin
            state   <= S_ADDR;
            bitcnt  <= '0;
            sda_drv <= 1'b0;
            staged  <= 1'b0;
            if (staged) pg_abort_o <= 1'b1;
        end else if (evt.stop) begin
            state   <= S_IDLE;
            sda_drv <= 1'b0;
            staged  <= 1'b0;
            if (staged) begin
                if (wr_en_i) pg_commit_o <= 1'b1;
                else         pg_abort_o  <= 1'b1;
            end
        end else begin
            case (state)
                S_ADDR, S_WADDR, S_WDATA: begin
                    if (evt.rise && bitcnt < CNT_W'(DATA_W)) begin
                        rxsh   <= {rxsh[DATA_W-2:0], evt.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (evt.fall && bitcnt == CNT_W'(DATA_W)) begin
                        bitcnt <= '0;
                        if (state == S_ADDR) begin
                            if (addr_ok) begin
                                sda_drv   <= 1'b1;
                                cur_bank  <= sel_bank;
                                is_read   <= rxsh[0];
                                after_ack <= rxsh[0] ? S_RDATA : S_WADDR;
                                state     <= S_ACK;
                            end else begin
                                state <= S_WAIT;
                            end
                        end else if (state == S_WADDR) begin
                            ctr[cur_bank] <= rxsh;
                            wptr          <= rxsh;
                            sda_drv       <= 1'b1;
                            after_ack     <= S_WDATA;
                            state         <= S_ACK;
                        end else begin
                            pg_push_o     <= 1'b1;
                            pg_bank_o     <= cur_bank;
                            pg_addr_o     <= wptr;
                            pg_data_o     <= rxsh;
                            ctr[cur_bank] <= wptr;
                            wptr          <= page_next(wptr, PAGE_BITS);
                            staged        <= 1'b1;
                            sda_drv       <= 1'b1;
                            after_ack     <= S_WDATA;
                            state         <= S_ACK;
                        end
                    end
                end
                S_ACK, S_RLOAD: begin
                    if (evt.fall) begin
                        if (state == S_RLOAD || after_ack == S_RDATA) begin
                            txsh    <= rd_byte << 1;
                            sda_drv <= ~rd_byte[DATA_W-1];
                            bitcnt  <= CNT_W'(1);
                            state   <= S_RDATA;
                        end else begin
                            sda_drv <= 1'b0;
                            bitcnt  <= '0;
                            state   <= after_ack;
                        end
                    end
                end
                S_RDATA: begin
                    if (evt.fall) begin
                        if (bitcnt < CNT_W'(DATA_W)) begin
                            sda_drv <= ~txsh[DATA_W-1];
                            txsh    <= txsh << 1;
                            bitcnt  <= bitcnt + 1'b1;
                        end else begin
                            sda_drv       <= 1'b0;
                            ctr[cur_bank] <= ctr[cur_bank] + 1'b1;
                            state         <= S_RACK;
                        end
                    end
                end
                S_RACK: begin
                    if (evt.rise) state <= evt.sda ? S_WAIT : S_RLOAD;
                end
                default: ;
            endcase
        end
    end

    // R7: the slave never pulls SDA during the master's acknowledge slot
    assert_rack_release_R7: assert property (@(posedge clk) disable iff (rst)
        (state == S_RACK) |-> !sda_oe_o);

    // R7: SDA drive changes only right after a falling clock edge, START or STOP
    assert_sda_edge_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> ($past(evt.fall) || $past(evt.start) || $past(evt.stop)));

    // R3 and R4: an address acknowledge requires enable high and sequencer idle
    assert_ack_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (state == S_ACK && $past(state) == S_ADDR && !$past(rst)) |-> $past(wr_en_i && !seq_busy_i));

    // R2: an acknowledged address always holds a valid bank index
    assert_bank_valid_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_ACK) |-> (int'(cur_bank) < NBANK));

    // R5: a push and a commit never share a cycle
    assert_push_commit_R5: assert property (@(posedge clk) disable iff (rst)
        !(pg_push_o && pg_commit_o));

    // R8: read state reached only after an acknowledged read address
    assert_read_dir_R8: assert property (@(posedge clk) disable iff (rst)
        (state == S_RDATA) |-> is_read);

endmodule

// File: tb/tb_eeprom_bank_i2c_slave.sv
module tb_eeprom_bank_i2c_slave;

    localparam int H = 16;
    localparam int Q = H / 2;
    localparam int BUSY_CYC = 600;
    localparam int NVEC = 6;
    // {bank select code, address, data}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h01, 8'h11, 8'h3C},
        {8'h01, 8'h80, 8'hA5},
        {8'h02, 8'h20, 8'h5E},
        {8'h03, 8'hFF, 8'h5A},
        {8'h03, 8'h00, 8'hC3},
        {8'h02, 8'h7F, 8'h01}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic wr_en = 1'b1, busy = 1'b0;
    logic sda_oe, pg_push, pg_commit, pg_abort;
    logic [1:0] pg_bank;
    logic [7:0] pg_addr, pg_data;
    logic prog_we = 1'b0;
    logic [1:0] prog_bank = '0;
    logic [7:0] prog_addr = '0, prog_data = '0;
    wire sda_bus = m_sda & ~sda_oe;

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    eeprom_bank_i2c_slave dut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .wr_en_i(wr_en), .seq_busy_i(busy), .pg_push_o(pg_push), .pg_commit_o(pg_commit),
        .pg_abort_o(pg_abort), .pg_bank_o(pg_bank), .pg_addr_o(pg_addr), .pg_data_o(pg_data),
        .prog_we_i(prog_we), .prog_bank_i(prog_bank), .prog_addr_i(prog_addr), .prog_data_i(prog_data)
    );

    // write sequencer model
    logic [17:0] stage [16];
    int nst = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (pg_abort) nst = 0;
            if (pg_push && nst < 16) begin
                stage[nst] = {pg_bank, pg_addr, pg_data};
                nst++;
            end
            if (pg_commit) begin
                busy = 1'b1;
                for (int i = 0; i < nst; i++) begin
                    prog_we = 1'b1;
                    {prog_bank, prog_addr, prog_data} = stage[i];
                    @(negedge clk);
                end
                prog_we = 1'b0;
                nst = 0;
                repeat (BUSY_CYC) @(negedge clk);
                busy = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start;
        m_sda = 1'b1; w(Q);
        m_scl = 1'b1; w(H);
        m_sda = 1'b0; w(H);
        m_scl = 1'b0; w(Q);
    endtask

    task automatic i2c_stop;
        m_sda = 1'b0; w(Q);
        m_scl = 1'b1; w(H);
        m_sda = 1'b1; w(H);
    endtask

    task automatic tx_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; w(Q);
            m_scl = 1'b1; w(H);
            m_scl = 1'b0; w(Q);
        end
        m_sda = 1'b1; w(Q);
        m_scl = 1'b1; w(Q);
        ack = !sda_bus; w(Q);
        m_scl = 1'b0; w(Q);
    endtask

    task automatic rx_byte(input bit mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; w(Q);
            m_scl = 1'b1; w(Q);
            b[i] = sda_bus; w(Q);
            m_scl = 1'b0; w(Q);
        end
        m_sda = mack ? 1'b0 : 1'b1; w(Q);
        m_scl = 1'b1; w(H);
        m_scl = 1'b0; w(Q);
    endtask

    task automatic wait_idle;
        w(20);
        while (busy) w(1);
        w(20);
    endtask

    task automatic byte_write(input logic [1:0] p, input logic [7:0] a, input logic [7:0] d, output bit ok);
        bit k1, k2, k3;
        i2c_start;
        tx_byte({4'b1010, 1'b0, p, 1'b0}, k1);
        tx_byte(a, k2);
        tx_byte(d, k3);
        i2c_stop;
        ok = k1 & k2 & k3;
    endtask

    task automatic rand_read(input logic [1:0] p, input logic [7:0] a, output logic [7:0] d, output bit ok);
        bit k1, k2, k3;
        i2c_start;
        tx_byte({4'b1010, 1'b0, p, 1'b0}, k1);
        tx_byte(a, k2);
        i2c_start;
        tx_byte({4'b1010, 1'b0, p, 1'b1}, k3);
        rx_byte(1'b0, d);
        i2c_stop;
        ok = k1 & k2 & k3;
    endtask

    task automatic cur_read(input logic [1:0] p, output logic [7:0] d, output bit ok);
        i2c_start;
        tx_byte({4'b1010, 1'b0, p, 1'b1}, ok);
        rx_byte(1'b0, d);
        i2c_stop;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        finish_run;
    end

    initial begin
        logic [7:0] d, d2;
        bit ok, ack;
        w(5);
        rst = 1'b0;
        w(10);

        // R10: reset state
        check(sda_oe == 1'b0, "R10 sda released", 32'(sda_oe), 0);
        cur_read(2'b01, d, ok);
        check(ok, "R10 ack", 32'(ok), 1);
        check(d == 8'hFF, "R10 erased data", 32'(d), 32'hFF);

        // R5 and R7: table walk, byte write then random read
        for (int i = 0; i < NVEC; i++) begin
            byte_write(VEC[i][17:16], VEC[i][15:8], VEC[i][7:0], ok);
            check(ok, "R5 byte write ack", 32'(ok), 1);
            wait_idle;
            rand_read(VEC[i][17:16], VEC[i][15:8], d, ok);
            check(ok && d == VEC[i][7:0], "R7 random read", 32'(d), 32'(VEC[i][7:0]));
        end

        // R5: page write wraps inside the 8-byte page
        i2c_start;
        tx_byte(8'b1010_0100, ack);
        tx_byte(8'h0E, ack);
        tx_byte(8'hA1, ack);
        tx_byte(8'hA2, ack);
        tx_byte(8'hA3, ack);
        check(ack, "R5 page data ack", 32'(ack), 1);
        i2c_stop;
        wait_idle;
        // R9: current read after write returns last written address (08h)
        cur_read(2'b10, d, ok);
        check(d == 8'hA3, "R9 current after write", 32'(d), 32'hA3);
        rand_read(2'b10, 8'h0F, d, ok);
        check(d == 8'hA2, "R5 page byte 0Fh", 32'(d), 32'hA2);
        rand_read(2'b10, 8'h0E, d, ok);
        check(d == 8'hA1, "R5 page byte 0Eh", 32'(d), 32'hA1);
        // R9: current read after read returns next address
        cur_read(2'b10, d, ok);
        check(d == 8'hA2, "R9 current after read", 32'(d), 32'hA2);
        rand_read(2'b10, 8'h10, d, ok);
        check(d == 8'hFF, "R5 no spill past page", 32'(d), 32'hFF);

        // R8: sequential read wraps FFh to 00h in bank 3
        i2c_start;
        tx_byte(8'b1010_0110, ack);
        tx_byte(8'hFF, ack);
        i2c_start;
        tx_byte(8'b1010_0111, ack);
        rx_byte(1'b1, d);
        rx_byte(1'b0, d2);
        check(d == 8'h5A, "R8 first byte", 32'(d), 32'h5A);
        check(d2 == 8'hC3, "R8 wrapped byte", 32'(d2), 32'hC3);
        // R8: after NACK the bus stays released over a further clock
        m_sda = 1'b1; w(Q);
        m_scl = 1'b1; w(Q);
        check(sda_bus == 1'b1, "R8 released after nack", 32'(sda_bus), 1);
        w(Q);
        m_scl = 1'b0; w(Q);
        i2c_stop;

        // R11: bank counters are independent
        rand_read(2'b01, 8'h10, d, ok);
        rand_read(2'b10, 8'h20, d, ok);
        check(d == 8'h5E, "R11 bank2 read", 32'(d), 32'h5E);
        cur_read(2'b01, d, ok);
        check(d == 8'h3C, "R11 bank1 counter kept", 32'(d), 32'h3C);

        // R1: wrong device type
        i2c_start;
        tx_byte(8'b1011_0010, ack);
        i2c_stop;
        check(!ack, "R1 wrong type nack", 32'(ack), 0);
        // R1: bit 3 set
        i2c_start;
        tx_byte(8'b1010_1010, ack);
        i2c_stop;
        check(!ack, "R1 bit3 set nack", 32'(ack), 0);
        // R2: bank code 00
        i2c_start;
        tx_byte(8'b1010_0001, ack);
        i2c_stop;
        check(!ack, "R2 bank 00 nack", 32'(ack), 0);
        // R3: enable low
        wr_en = 1'b0;
        i2c_start;
        tx_byte(8'b1010_0011, ack);
        i2c_stop;
        wr_en = 1'b1;
        check(!ack, "R3 enable low nack", 32'(ack), 0);

        // R4: busy sequencer refuses the address
        byte_write(2'b01, 8'h30, 8'h44, ok);
        w(30);
        i2c_start;
        tx_byte(8'b1010_0010, ack);
        i2c_stop;
        check(!ack, "R4 busy nack", 32'(ack), 0);
        wait_idle;
        rand_read(2'b01, 8'h30, d, ok);
        check(d == 8'h44, "R4 write after busy", 32'(d), 32'h44);

        // R6: repeated START discards staged data
        i2c_start;
        tx_byte(8'b1010_0010, ack);
        tx_byte(8'h40, ack);
        tx_byte(8'h77, ack);
        i2c_start;
        i2c_stop;
        wait_idle;
        rand_read(2'b01, 8'h40, d, ok);
        check(d == 8'hFF, "R6 aborted write", 32'(d), 32'hFF);

        // R3: enable dropped before STOP discards the write
        i2c_start;
        tx_byte(8'b1010_0010, ack);
        tx_byte(8'h50, ack);
        tx_byte(8'h99, ack);
        wr_en = 1'b0;
        i2c_stop;
        wr_en = 1'b1;
        wait_idle;
        rand_read(2'b01, 8'h50, d, ok);
        check(d == 8'hFF, "R3 write dropped", 32'(d), 32'hFF);

        finish_run;
    end

endmodule